// File: doc/BRIEF.md
# Encoded Integer ALU

A purely combinational arithmetic and logic unit. It takes two operands and a 3-bit operation code, and it produces a result word and a flag that is high when that result is all zeros. The operations are wrapping addition and subtraction, bitwise AND, OR and XOR, and a signed less-than test. The operation code selects one of them.

The block sits in the execute path of a simple processor datapath. The decoder drives the operation code, and the zero flag feeds branch resolution. The block holds no state, so the outputs follow the inputs within the same cycle.

Top module: `alu_core`

## Requirements
- R1: Code 3'b010 gives result = a + b modulo 2^WIDTH.
- R2: Code 3'b110 gives result = a - b modulo 2^WIDTH.
- R3: Code 3'b000 gives the bitwise AND of a and b.
- R4: Code 3'b001 gives the bitwise OR of a and b.
- R5: Code 3'b011 gives the bitwise XOR of a and b.
- R6: Code 3'b111 compares a and b as two's-complement signed values. Bit 0 of the result is 1 when a < b, and every other result bit is 0.
- R7: Codes 3'b100 and 3'b101 give an all-zero result.
- R8: zero_o is 1 exactly when the result equals zero, for every code.
- R9: The outputs follow a change on any input within the same cycle, with no clock or register involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | WIDTH | First operand |
| src_b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The signed compare is the case most easily missed. It needs operand pairs whose signs differ and whose unsigned order is the reverse of their signed order, for example the most negative value against small positive values or against the most positive value. The bench applies a fixed list of such sign-boundary pairs, together with wrap-around pairs for addition and subtraction. Each pair is run under all eight codes, and the list is followed by a deterministic pseudo-random sweep. Results of zero under the unused codes and under subtraction of equal operands exercise the flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_XOR  = 3'b011,
    OP_RSV4 = 3'b100,
    OP_RSV5 = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign and_o[g] = a_i[g] & b_i[g];
    assign or_o[g]  = a_i[g] | b_i[g];
    assign xor_o[g] = a_i[g] ^ b_i[g];
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             lt_o
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] b_inv;

  // One adder serves add, subtract and compare
  assign b_inv = b_i ^ {WIDTH{sub_i}};
  assign sum_o = a_i + b_inv + {{(WIDTH-1){1'b0}}, sub_i};

  // Differing signs: a is less when it is the negative one
  assign lt_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] and_w, or_w, xor_w, sum_w;
  logic             lt_w, use_sub;

  assign op      = alu_op_e'(op_i);
  assign use_sub = (op == OP_SUB) || (op == OP_SLT);

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i(src_a_i), .b_i(src_b_i),
    .and_o(and_w), .or_o(or_w), .xor_o(xor_w)
  );

  alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .a_i(src_a_i), .b_i(src_b_i), .sub_i(use_sub),
    .sum_o(sum_w), .lt_o(lt_w)
  );

  always_comb begin
    unique case (op)
      OP_AND:          result_o = and_w;
      OP_OR:           result_o = or_w;
      OP_XOR:          result_o = xor_w;
      OP_ADD, OP_SUB:  result_o = sum_w;
      OP_SLT:          result_o = {{(WIDTH-1){1'b0}}, lt_w};
      default:         result_o = '0;
    endcase
  end

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .val_i(result_o), .zero_o(zero_o)
  );
endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] src_a_i,
  input logic [WIDTH-1:0] src_b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);
  always_comb begin
    if (!$isunknown({src_a_i, src_b_i, op_i})) begin
      if (op_i == 3'b010)
        p_add_inverse_r1: assert (result_o - src_b_i == src_a_i) else $error("add");
      if (op_i == 3'b110)
        p_sub_inverse_r2: assert (result_o + src_b_i == src_a_i) else $error("sub");
      if (op_i == 3'b000)
        p_and_subset_r3: assert ((result_o & ~src_a_i) == '0) else $error("and");
      if (op_i == 3'b001)
        p_or_cover_r4: assert ((result_o & src_a_i) == src_a_i) else $error("or");
      if (op_i == 3'b111) begin
        p_slt_upper_r6: assert (result_o[WIDTH-1:1] == '0) else $error("slt upper");
        p_slt_value_r6: assert (result_o[0] == ($signed(src_a_i) < $signed(src_b_i)))
          else $error("slt");
      end
      if (op_i == 3'b100 || op_i == 3'b101)
        p_unused_zero_r7: assert (result_o == '0 && zero_o) else $error("unused");
      p_zero_flag_r8: assert (zero_o == (result_o == '0)) else $error("zero flag");
    end
  end
endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_alu_core_checker (
  .src_a_i(src_a_i), .src_b_i(src_b_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  localparam int  W      = 32;
  localparam time CLK_PD = 10ns;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, res;
  logic [2:0]   op;
  logic         zf;
  int           n_chk = 0, n_fail = 0;
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  always #(CLK_PD/2) clk = ~clk;

  alu_core #(.WIDTH(W)) dut_i (
    .src_a_i(a), .src_b_i(b), .op_i(op), .result_o(res), .zero_o(zf)
  );

  function automatic logic [W-1:0] ref_res(int code, logic [W-1:0] x, logic [W-1:0] y);
    case (code)
      0: return x & y;
      1: return x | y;
      2: return x + y;
      3: return x ^ y;
      6: return x - y;
      7: return ($signed(x) < $signed(y)) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag(int code);
    case (code)
      0: return "R3"; 1: return "R4"; 2: return "R1"; 3: return "R5";
      6: return "R2"; 7: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op %b a %h b %h)", req, act, exp, op, a, b);
    end
  endtask

  // drive at the rising edge, sample at the falling edge
  task automatic apply(int code, logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] e;
    @(posedge clk);
    op = 3'(code); a = x; b = y;
    @(negedge clk);
    e = ref_res(code, x, y);
    check(tag(code), res, e);
    check("R8", {31'b0, zf}, {31'b0, (e == 0)});
  endtask

  logic [W-1:0] ca [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000,
                            32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h5};
  logic [W-1:0] cb [10] = '{32'h0, 32'h1, 32'h1, 32'h1, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h3};

  initial begin
    #(CLK_PD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = 3'b000;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R3", res, '0);
    check("R8", {31'b0, zf}, 32'h1);

    // signed boundaries: MSB set against positive values
    apply(7, 32'h8000_0000, 32'h0000_0001);  check("R6", res, 32'h1);
    apply(7, 32'h0000_0001, 32'h8000_0000);  check("R6", res, 32'h0);
    apply(7, 32'hFFFF_FFFF, 32'h0000_0000);  check("R6", res, 32'h1);
    apply(2, 32'hFFFF_FFFF, 32'h0000_0001);  check("R1", res, 32'h0);
    apply(6, 32'h0000_0000, 32'h0000_0001);  check("R2", res, 32'hFFFF_FFFF);
    apply(5, 32'hDEAD_BEEF, 32'h1234_5678);  check("R7", res, 32'h0);

    // R9: outputs track a mid-cycle input change with no clock edge
    @(posedge clk); op = 3'b011; a = 32'hF0F0_F0F0; b = 32'h0F0F_0F0F;
    #1; check("R9", res, 32'hFFFF_FFFF);
    b = 32'hF0F0_F0F0;
    #1; check("R9", res, 32'h0);
    check("R9", {31'b0, zf}, 32'h1);

    for (int i = 0; i < 10; i++)
      for (int c = 0; c < 8; c++) apply(c, ca[i], cb[i]);

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] x, y;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      x = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      y = (i % 7 == 0) ? x : lfsr;
      for (int c = 0; c < 8; c++) apply(c, x, y);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule